// File: doc/BRIEF.md
# Dual-Channel Serial Port Register Bank

This block holds the software-visible byte registers of two identical serial channels. Each channel has six registers: mode, bit rate, control, transmit data, status and receive data. A simple synchronous bus reaches them with byte or halfword accesses. Reads are registered, so the data for a read strobe appears on `bus_rdata` one clock later. The decode is partial. The top address nibble must be 0x5 and the low nine bits select the register. Address bits 23 to 9 are ignored, so every value in that band aliases onto the same register.

The serial receiver outside this block assembles each incoming byte (least significant bit first) in a shift register. When the byte is complete, the receiver pulses `rx_done` for the channel and presents the byte. The bank copies that byte into the read-only receive data register and sets a receive-full flag in status. The shift register is then free again at once, which gives double buffering. Status flags can only be cleared by software. Hardware alone sets them.

Top module: `serial_regbank`

## Requirements
- R1: After reset, each channel's registers hold: mode 0x00, bit rate 0xFF, control 0x00, transmit data 0xFF, status 0x84, receive data 0x00. `bus_rdata` is 0x0000.
- R2: The low nine address bits place channel 0's mode, bit rate, control, transmit data, status and receive data registers at 0x0C0..0x0C5 in that order. Channel 1's registers follow the same order at 0x0C8..0x0CD.
- R3: An access is decoded only when address bits 27:24 equal 0x5. Bits 23:9 take no part in the decode. An access with any other top nibble reads 0x0000 and writes nothing.
- R4: A byte access (`bus_size`=0) returns the register on `bus_rdata[7:0]` with `bus_rdata[15:8]`=0, one cycle after `bus_re`. A byte write takes `bus_wdata[7:0]`.
- R5: A halfword access (`bus_size`=1) at an even address maps the even-offset register to bits 15:8 and the next register to bits 7:0, for both reads and writes.
- R6: A halfword access at an odd address writes nothing and reads 0x0000.
- R7: Bus writes to the receive data register are ignored.
- R8: A status bit is cleared by writing 0 to it. Writing 1 leaves the bit unchanged, and no bus write can set a status bit.
- R9: A one-cycle `rx_done` pulse for a channel loads that channel's byte into its receive data register on the next cycle. Pulses on consecutive cycles each land, and the last one wins.
- R10: Status bit 6 (receive-full) is set by every receive transfer. If a bus write clears it in the same cycle, the set wins.
- R11: Offsets inside the decoded window that name no register (0x0C6, 0x0C7, 0x0CE, 0x0CF) and offsets outside it read 0 and ignore writes.
- R12: A write or a receive transfer on one channel leaves the other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 28 | Byte address |
| bus_size | input | 1 | 0 = byte, 1 = halfword |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| rx_done | input | 2 | Per-channel byte-complete pulse |
| rx_byte | input | 16 | Assembled bytes, channel c on bits 8c+7:8c |

## Verification
Register reads are tried at the canonical address and at aliases that differ only in bits 23:9. Matching values show that the middle band is ignored, and a changed top nibble shows that it is not. Halfword reads at even and odd addresses separate the lane order from the misalignment rule. Status writes use patterns of all ones, a single zero and all zeros, which distinguish clear-only behaviour from a plain store. Receive pulses are given alone, back to back, and in the same cycle as a status clear. These cases show the double buffering, the set-over-clear priority and the isolation between the two channels.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int NCH    = 2;
  localparam int NREG   = 6;
  localparam int DW     = 8;
  localparam int IDX_W  = 3;
  localparam int STRIDE = 8;

  localparam int R_MODE = 0;
  localparam int R_BAUD = 1;
  localparam int R_CTRL = 2;
  localparam int R_TXD  = 3;
  localparam int R_STAT = 4;
  localparam int R_RXD  = 5;

  localparam int RXF_BIT = 6;

  localparam logic [NREG-1:0][DW-1:0] RESET_IMG =
    {8'h00, 8'h84, 8'hFF, 8'h00, 8'hFF, 8'h00};

  typedef struct packed {
    logic             hi_hit;
    logic             lo_hit;
    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] lo_idx;
  } lane_sel_t;
endpackage

// File: rtl/srb_rst_sync.sv
module srb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/srb_decode.sv
module srb_decode
  import srb_pkg::*;
#(
  parameter int          ADDR_W   = 28,
  parameter logic [3:0]  AREA_ID  = 4'h5,
  parameter logic [8:0]  WIN_BASE = 9'h0C0,
  parameter int          CH_W     = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              half,
  output lane_sel_t         sel,
  output logic [CH_W-1:0]   ch
);
  localparam int WIN_SIZE = NCH * STRIDE;

  logic [8:0]       off;
  logic [8:0]       rel;
  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic [IDX_W:0]   idx_nx;

  always_comb begin
    off    = addr[8:0];
    rel    = off - WIN_BASE;
    in_win = (addr[ADDR_W-1 -: 4] == AREA_ID) && (off >= WIN_BASE) &&
             (32'(rel) < WIN_SIZE);
    ch     = rel[3 +: CH_W];
    idx    = rel[IDX_W-1:0];
    idx_nx = {1'b0, idx} + 1'b1;
    sel    = '0;
    if (!half) begin
      sel.lo_hit = in_win && (32'(idx) < NREG);
      sel.lo_idx = idx;
    end else if (!off[0]) begin
      sel.hi_hit = in_win && (32'(idx) < NREG);
      sel.hi_idx = idx;
      sel.lo_hit = in_win && (32'(idx_nx) < NREG);
      sel.lo_idx = idx_nx[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/srb_channel.sv
module srb_channel
  import srb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREG-1:0]           wen,
  input  logic [NREG-1:0][DW-1:0]   wdat,
  input  logic                      rx_valid,
  input  logic [DW-1:0]             rx_data,
  output logic [NREG-1:0][DW-1:0]   regs_o
);
  logic [NREG-1:0][DW-1:0] regs_q, regs_d;
  logic                    upd;

  always_comb begin
    regs_d = regs_q;
    for (int i = 0; i < NREG; i++) begin
      if (wen[i]) begin
        if (i == R_STAT)     regs_d[i] = regs_q[i] & wdat[i];
        else if (i != R_RXD) regs_d[i] = wdat[i];
      end
    end
    if (rx_valid) begin
      regs_d[R_RXD]          = rx_data;
      regs_d[R_STAT][RXF_BIT] = 1'b1;
    end
    upd = (|wen) | rx_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   regs_q <= RESET_IMG;
    else if (upd) regs_q <= regs_d;
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
  import srb_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_size,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [15:0]       bus_rdata,
  input  logic [NCH-1:0]    rx_done,
  input  logic [NCH*DW-1:0] rx_byte
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic                              rst_i;
  lane_sel_t                         sel;
  logic [CH_W-1:0]                   ch;
  logic [NCH-1:0][NREG-1:0][DW-1:0]  chan_regs;
  logic [15:0]                       rd_d, rd_q;

  srb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i)
  );

  srb_decode #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
    .addr(bus_addr), .half(bus_size), .sel(sel), .ch(ch)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NREG-1:0]         wen;
    logic [NREG-1:0][DW-1:0] wdat;
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic hi_sel, lo_sel;
      assign hi_sel  = sel.hi_hit && (sel.hi_idx == IDX_W'(r));
      assign lo_sel  = sel.lo_hit && (sel.lo_idx == IDX_W'(r));
      assign wen[r]  = bus_we && (ch == CH_W'(c)) && (hi_sel || lo_sel);
      assign wdat[r] = hi_sel ? bus_wdata[15:8] : bus_wdata[7:0];
    end
    srb_channel u_ch (
      .clk(clk), .rst_n(rst_i), .wen(wen), .wdat(wdat),
      .rx_valid(rx_done[c]), .rx_data(rx_byte[c*DW +: DW]),
      .regs_o(chan_regs[c])
    );
  end

  always_comb begin
    rd_d = '0;
    if (sel.hi_hit) rd_d[15:8] = chan_regs[ch][sel.hi_idx];
    if (sel.lo_hit) rd_d[7:0]  = chan_regs[ch][sel.lo_idx];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      rd_q <= '0;
    else if (bus_re) rd_q <= rd_d;
  end

  assign bus_rdata = rd_q;
endmodule

// File: rtl/srb_checker.sv
module srb_checker
  import srb_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input logic                             clk,
  input logic                             rst_i,
  input logic [ADDR_W-1:0]                bus_addr,
  input logic                             bus_size,
  input logic                             bus_re,
  input logic [15:0]                      bus_rdata,
  input logic [NCH-1:0]                   rx_done,
  input logic [NCH*DW-1:0]                rx_byte,
  input logic [NCH-1:0][NREG-1:0][DW-1:0] chan_regs
);
  a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_re && !bus_size) |=> (bus_rdata[15:8] == 8'h00));

  a_r6_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_re && bus_size && bus_addr[0]) |=> (bus_rdata == 16'h0000));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r9_rx_load: assert property (@(posedge clk) disable iff (!rst_i)
      rx_done[c] |=> (chan_regs[c][R_RXD] == $past(rx_byte[c*DW +: DW])));

    a_r10_flag_set_wins: assert property (@(posedge clk) disable iff (!rst_i)
      rx_done[c] |=> chan_regs[c][R_STAT][RXF_BIT]);

    a_r7_rxd_bus_proof: assert property (@(posedge clk) disable iff (!rst_i)
      !rx_done[c] |=> $stable(chan_regs[c][R_RXD]));

    a_r8_no_bus_set: assert property (@(posedge clk) disable iff (!rst_i)
      !rx_done[c] |=> ((chan_regs[c][R_STAT] & ~$past(chan_regs[c][R_STAT])) == 8'h00));
  end
endmodule

bind serial_regbank srb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_i(rst_i), .bus_addr(bus_addr), .bus_size(bus_size),
  .bus_re(bus_re), .bus_rdata(bus_rdata), .rx_done(rx_done),
  .rx_byte(rx_byte), .chan_regs(chan_regs)
);

// File: tb/sim_serial_regbank.sv
`timescale 1ns/1ps
module sim_serial_regbank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [27:0] bus_addr;
  logic        bus_size;
  logic [15:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [15:0] bus_rdata;
  logic [1:0]  rx_done;
  logic [15:0] rx_byte;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  serial_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .rx_done(rx_done), .rx_byte(rx_byte)
  );

  function automatic logic [27:0] ad(input logic [8:0] off);
    return {4'h5, 15'h0000, off};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [27:0] a, input logic sz, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_size = sz; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wr(input logic [27:0] a, input logic sz, input logic [15:0] d);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rx(input int c, input logic [7:0] b);
    rx_done[c] = 1'b1;
    rx_byte[c*8 +: 8] = b;
    @(negedge clk);
    rx_done = '0;
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: compare each registered read result against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (bus_re) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("scoreboard empty", bus_rdata, 16'hxxxx);
        else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_size = 1'b0; bus_wdata = '0;
    bus_we = 1'b0; bus_re = 1'b0; rx_done = '0; rx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 16'h0000);

    // R1/R2/R4 reset values, byte reads, channel 0
    rd(ad(9'h0C0), 0, 16'h0000, "R1 R2 mode0");
    rd(ad(9'h0C1), 0, 16'h00FF, "R1 R2 baud0");
    rd(ad(9'h0C2), 0, 16'h0000, "R1 R2 ctrl0");
    rd(ad(9'h0C3), 0, 16'h00FF, "R1 R4 txd0");
    rd(ad(9'h0C4), 0, 16'h0084, "R1 R4 stat0");
    rd(ad(9'h0C5), 0, 16'h0000, "R1 R4 rxd0");
    // R1/R5 channel 1 halfwords
    rd(ad(9'h0C8), 1, 16'h00FF, "R1 R5 mode1/baud1");
    rd(ad(9'h0CA), 1, 16'h00FF, "R1 R5 ctrl1/txd1");
    rd(ad(9'h0CC), 1, 16'h8400, "R1 R5 stat1/rxd1");

    // R3 alias decode
    wr(28'h5ABCEC0, 0, 16'h003A);
    rd(ad(9'h0C0), 0, 16'h003A, "R3 alias write");
    rd(28'h57FFEC0, 0, 16'h003A, "R3 alias read");
    wr(28'h40000C2, 0, 16'h0055);
    rd(ad(9'h0C2), 0, 16'h0000, "R3 wrong area write");
    rd(28'h40000C0, 0, 16'h0000, "R3 wrong area read");

    // R5 halfword write, R12 isolation
    wr(ad(9'h0C8), 1, 16'h1234);
    rd(ad(9'h0C8), 0, 16'h0012, "R5 hi lane");
    rd(ad(9'h0C9), 0, 16'h0034, "R5 lo lane");
    rd(ad(9'h0C0), 0, 16'h003A, "R12 ch0 mode kept");

    // R6 misaligned
    wr(ad(9'h0C3), 1, 16'hBEEF);
    rd(ad(9'h0C3), 0, 16'h00FF, "R6 txd0 untouched");
    rd(ad(9'h0C4), 0, 16'h0084, "R6 stat0 untouched");
    rd(ad(9'h0C1), 1, 16'h0000, "R6 misaligned read");

    // R7 read-only receive data, R8 clear-only status
    wr(ad(9'h0C5), 0, 16'h0077);
    rd(ad(9'h0C5), 0, 16'h0000, "R7 rxd byte write ignored");
    wr(ad(9'h0C4), 1, 16'hFF77);
    rd(ad(9'h0C4), 1, 16'h8400, "R7 R8 halfword stat/rxd");
    wr(ad(9'h0C4), 0, 16'h007F);
    rd(ad(9'h0C4), 0, 16'h0004, "R8 clear bit7");
    wr(ad(9'h0C4), 0, 16'h0000);
    rd(ad(9'h0C4), 0, 16'h0000, "R8 clear all");
    wr(ad(9'h0C4), 0, 16'h00FF);
    rd(ad(9'h0C4), 0, 16'h0000, "R8 ones do not set");

    // R9 receive transfer, R12 isolation
    rx(0, 8'hA5);
    rd(ad(9'h0C5), 0, 16'h00A5, "R9 rxd0 loaded");
    rd(ad(9'h0C4), 0, 16'h0040, "R10 rx full flag ch0");
    rd(ad(9'h0CC), 1, 16'h8400, "R12 ch1 untouched by ch0 rx");
    rx(1, 8'h3C);
    rd(ad(9'h0CD), 0, 16'h003C, "R9 rxd1 loaded");
    rd(ad(9'h0CC), 0, 16'h00C4, "R10 rx full flag ch1");
    rd(ad(9'h0C5), 0, 16'h00A5, "R12 ch0 rxd kept");
    wr(ad(9'h0CC), 0, 16'h00BF);
    rd(ad(9'h0CC), 0, 16'h0084, "R8 clear rx full ch1");

    // R10 set beats same-cycle clear
    bus_addr = ad(9'h0C4); bus_size = 1'b0; bus_wdata = 16'h0000; bus_we = 1'b1;
    rx_done[0] = 1'b1; rx_byte[7:0] = 8'h5A;
    @(negedge clk);
    bus_we = 1'b0; rx_done = '0;
    rd(ad(9'h0C4), 0, 16'h0040, "R10 set wins over clear");
    rd(ad(9'h0C5), 0, 16'h005A, "R10 rxd loaded with clear");

    // R9 back-to-back transfers
    rx(0, 8'h11);
    rx(0, 8'h22);
    rd(ad(9'h0C5), 0, 16'h0022, "R9 back-to-back last wins");

    // R11 unmapped offsets
    rd(ad(9'h0C6), 0, 16'h0000, "R11 hole read");
    wr(ad(9'h0C7), 0, 16'h0055);
    rd(ad(9'h0C7), 0, 16'h0000, "R11 hole write ignored");
    wr(ad(9'h0C6), 1, 16'hAAAA);
    rd(ad(9'h0C6), 1, 16'h0000, "R11 halfword hole");
    rd(ad(9'h0C4), 1, 16'h4022, "R11 neighbours kept");
    wr(ad(9'h0D0), 0, 16'h0099);
    rd(ad(9'h0D0), 0, 16'h0000, "R11 outside window");
    rd(ad(9'h0CE), 0, 16'h0000, "R11 ch1 hole");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard drained", 16'(exp_q.size()), 16'h0000);
    finish_up();
  end
endmodule